// File: doc/BRIEF.md
# Burst Byte Count Monitor

A passive observer that taps the read and write channels of a memory-mapped burst bus and reports, once per transaction, how many bytes that transaction actually moved. It never drives the bus: it only samples handshakes, so it can be attached next to any manager or subordinate port for bandwidth accounting or traffic checking.

On the read side the count is computed from the request: the beat width follows from the size field, the start offset inside a beat shortens the first beat, and the burst kind decides whether later beats are full width (incrementing), equal to the shortened first beat (fixed) or full width from an aligned start (wrapping). On the write side the request fields are used only for error screening; the count is the number of asserted byte strobes over every accepted data beat. Each direction allows one transaction in flight. A result is presented together with a one-cycle done pulse and an error flag, and then held until the next result.

Top module: `burst_byte_meter`

## Requirements
- R1: Read request fields (offset, size, length, burst kind) are captured only in a cycle where both `ar_valid` and `ar_ready` are high; changes to them in other cycles do not alter the reported count.
- R2: For an incrementing read (burst code 1), with beat width W = 2^size and offset O = address mod W, the count is (W - O) + length_field * W.
- R3: For a fixed read (burst code 0), the count is (length_field + 1) * (W - O).
- R4: For a wrapping read (burst code 2), the count is (length_field + 1) * W.
- R5: A read with burst code 3 reports `rd_err` = 1 and `rd_bytes` = 0.
- R6: A read whose size gives W larger than the bus byte width (size > 2 for a 32-bit bus) reports `rd_err` = 1 and `rd_bytes` = 0.
- R7: `rd_done` is high for exactly the one cycle after a cycle with `r_valid`, `r_ready` and `r_last` all high; a last beat without `r_ready` does not finish the read.
- R8: The write count is the sum of set bits of `w_strb` over beats where `w_valid` and `w_ready` are both high; beats without `w_ready` add nothing.
- R9: `wr_done` is high for one cycle after the accepted beat with `w_last`; the strobe sum restarts from zero at each write request handshake, discarding beats seen before it.
- R10: A write whose request has burst code 3 or an oversized size reports `wr_err` = 1 and `wr_bytes` = 0.
- R11: The count outputs hold 256 beats of the full bus width without overflow (1024 for a 32-bit bus).
- R12: Reset clears both done pulses, both counts and both error flags.
- R13: Counts and error flags hold their value between done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ar_valid | input | 1 | Read request valid |
| ar_ready | input | 1 | Read request ready |
| ar_addr | input | OFS_W | Low address bits (offset within a bus word) of the read request |
| ar_size | input | 3 | Read beat size code, bytes = 2^code |
| ar_len | input | 8 | Read length field, beats = field + 1 |
| ar_burst | input | 2 | Read burst kind: 0 fixed, 1 incrementing, 2 wrapping, 3 reserved |
| r_valid | input | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_last | input | 1 | Read data last beat |
| aw_valid | input | 1 | Write request valid |
| aw_ready | input | 1 | Write request ready |
| aw_size | input | 3 | Write beat size code |
| aw_burst | input | 2 | Write burst kind |
| w_valid | input | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| w_strb | input | STRB_W | Write byte strobes |
| w_last | input | 1 | Write data last beat |
| rd_done | output | 1 | One-cycle pulse: read count updated |
| rd_bytes | output | CNT_W | Bytes moved by the last read |
| rd_err | output | 1 | Last read had a reserved burst or oversized size |
| wr_done | output | 1 | One-cycle pulse: write count updated |
| wr_bytes | output | CNT_W | Bytes written by the last write |
| wr_err | output | 1 | Last write had a reserved burst or oversized size |

## Verification
The assertions watch, every cycle, that captured request fields stay put without a handshake, that a done pulse only follows an accepted last beat, that an error result always carries a zero count, that the strobe sum does not move when no beat or request is accepted, and that counts stay within the 256-beat bound and hold between results. Only the bench's scenarios show that the arithmetic is right: the shortened first beat for misaligned incrementing and fixed bursts, full beats for wrapping bursts, the strobe totals with stalled beats, the restart of the sum on a new write request, and the longest burst.

// File: rtl/bbm_pkg.sv
package bbm_pkg;

  typedef enum logic [1:0] {
    BK_FIXED = 2'd0,
    BK_INCR  = 2'd1,
    BK_WRAP  = 2'd2,
    BK_RSVD  = 2'd3
  } burst_kind_e;

  // Captured read request. Only offset bits inside the widest beat are kept.
  typedef struct packed {
    logic [6:0]  ofs;
    logic [2:0]  size;
    logic [7:0]  len;
    burst_kind_e kind;
  } rd_req_t;

  function automatic int unsigned beat_width(input logic [2:0] size);
    return 32'd1 << size;
  endfunction

  // Bytes carried by the first beat: the width minus the misalignment.
  function automatic int unsigned lead_bytes(input rd_req_t q);
    int unsigned w;
    w = beat_width(q.size);
    return w - (32'(q.ofs) & (w - 32'd1));
  endfunction

  function automatic logic req_bad(input logic [2:0] size, input burst_kind_e kind,
                                   input int max_size);
    return (kind == BK_RSVD) || (int'(size) > max_size);
  endfunction

  function automatic int unsigned read_total(input rd_req_t q);
    int unsigned w;
    int unsigned beats;
    w     = beat_width(q.size);
    beats = 32'(q.len) + 32'd1;
    case (q.kind)
      BK_FIXED: return beats * lead_bytes(q);
      BK_INCR:  return lead_bytes(q) + 32'(q.len) * w;
      BK_WRAP:  return beats * w;
      default:  return 32'd0;
    endcase
  endfunction

endpackage

// File: rtl/bbm_strb_popcount.sv
module bbm_strb_popcount #(
  parameter int W  = 4,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] ones
);
  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) begin
      ones = ones + CW'(vec[i]);
    end
  end
endmodule

// File: rtl/bbm_rd_path.sv
module bbm_rd_path
  import bbm_pkg::*;
#(
  parameter int STRB_W = 4,
  parameter int OFS_W  = $clog2(STRB_W),
  parameter int CNT_W  = $clog2(256 * STRB_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ar_valid,
  input  logic             ar_ready,
  input  logic [OFS_W-1:0] ar_addr,
  input  logic [2:0]       ar_size,
  input  logic [7:0]       ar_len,
  input  logic [1:0]       ar_burst,
  input  logic             r_valid,
  input  logic             r_ready,
  input  logic             r_last,
  output logic             done,
  output logic [CNT_W-1:0] bytes,
  output logic             err
);
  localparam int MAX_SIZE  = $clog2(STRB_W);
  localparam int MAX_BYTES = 256 * STRB_W;

  rd_req_t req_q;
  rd_req_t req_in;

  // Named internal events
  logic ar_hs;
  logic r_fin;
  logic shape_bad;
  logic [CNT_W-1:0] total;

  assign ar_hs  = ar_valid & ar_ready;
  assign r_fin  = r_valid & r_ready & r_last;
  assign req_in = '{ofs: 7'(ar_addr), size: ar_size, len: ar_len,
                    kind: burst_kind_e'(ar_burst)};
  assign shape_bad = req_bad(req_q.size, req_q.kind, MAX_SIZE);
  assign total     = shape_bad ? '0 : CNT_W'(read_total(req_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '{ofs: '0, size: '0, len: '0, kind: BK_FIXED};
    end else if (ar_hs) begin
      req_q <= req_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done  <= 1'b0;
      bytes <= '0;
      err   <= 1'b0;
    end else begin
      done <= r_fin;
      if (r_fin) begin
        bytes <= total;
        err   <= shape_bad;
      end
    end
  end

  AST_RD_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ar_hs |=> $stable(req_q)); // R1
  AST_RD_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(r_valid && r_ready && r_last)); // R7
  AST_RD_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (bytes == '0)); // R5
  AST_RD_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (32'(bytes) <= MAX_BYTES)); // R11
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !r_fin |=> ($stable(bytes) && $stable(err))); // R13

endmodule

// File: rtl/bbm_wr_path.sv
module bbm_wr_path
  import bbm_pkg::*;
#(
  parameter int STRB_W = 4,
  parameter int CNT_W  = $clog2(256 * STRB_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aw_valid,
  input  logic              aw_ready,
  input  logic [2:0]        aw_size,
  input  logic [1:0]        aw_burst,
  input  logic              w_valid,
  input  logic              w_ready,
  input  logic [STRB_W-1:0] w_strb,
  input  logic              w_last,
  output logic              done,
  output logic [CNT_W-1:0]  bytes,
  output logic              err
);
  localparam int MAX_SIZE  = $clog2(STRB_W);
  localparam int MAX_BYTES = 256 * STRB_W;
  localparam int PC_W      = $clog2(STRB_W + 1);

  logic [2:0]  size_q;
  burst_kind_e kind_q;
  logic [CNT_W-1:0] acc_q;

  // Named internal events
  logic aw_hs;
  logic w_hs;
  logic w_fin;
  logic shape_bad;
  logic [PC_W-1:0]  beat_ones;
  logic [CNT_W-1:0] acc_base;
  logic [CNT_W-1:0] acc_sum;

  assign aw_hs     = aw_valid & aw_ready;
  assign w_hs      = w_valid & w_ready;
  assign w_fin     = w_hs & w_last;
  assign shape_bad = req_bad(size_q, kind_q, MAX_SIZE);
  assign acc_base  = aw_hs ? '0 : acc_q;
  assign acc_sum   = acc_base + CNT_W'(beat_ones);

  bbm_strb_popcount #(.W(STRB_W), .CW(PC_W)) u_pop (
    .vec  (w_strb),
    .ones (beat_ones)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q <= '0;
      kind_q <= BK_FIXED;
    end else if (aw_hs) begin
      size_q <= aw_size;
      kind_q <= burst_kind_e'(aw_burst);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (w_fin) begin
      acc_q <= '0;
    end else if (w_hs) begin
      acc_q <= acc_sum;
    end else if (aw_hs) begin
      acc_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done  <= 1'b0;
      bytes <= '0;
      err   <= 1'b0;
    end else begin
      done <= w_fin;
      if (w_fin) begin
        bytes <= shape_bad ? '0 : acc_sum;
        err   <= shape_bad;
      end
    end
  end

  AST_WR_ACC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!aw_hs && !w_hs) |=> $stable(acc_q)); // R8
  AST_WR_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(w_valid && w_ready && w_last)); // R9
  AST_WR_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (bytes == '0)); // R10
  AST_WR_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (32'(bytes) <= MAX_BYTES)); // R11
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !w_fin |=> ($stable(bytes) && $stable(err))); // R13

endmodule

// File: rtl/burst_byte_meter.sv
module burst_byte_meter #(
  parameter int DATA_W = 32,
  parameter int STRB_W = DATA_W / 8,
  parameter int OFS_W  = $clog2(STRB_W),
  parameter int CNT_W  = $clog2(256 * STRB_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ar_valid,
  input  logic              ar_ready,
  input  logic [OFS_W-1:0]  ar_addr,
  input  logic [2:0]        ar_size,
  input  logic [7:0]        ar_len,
  input  logic [1:0]        ar_burst,
  input  logic              r_valid,
  input  logic              r_ready,
  input  logic              r_last,
  input  logic              aw_valid,
  input  logic              aw_ready,
  input  logic [2:0]        aw_size,
  input  logic [1:0]        aw_burst,
  input  logic              w_valid,
  input  logic              w_ready,
  input  logic [STRB_W-1:0] w_strb,
  input  logic              w_last,
  output logic              rd_done,
  output logic [CNT_W-1:0]  rd_bytes,
  output logic              rd_err,
  output logic              wr_done,
  output logic [CNT_W-1:0]  wr_bytes,
  output logic              wr_err
);

  bbm_rd_path #(.STRB_W(STRB_W), .OFS_W(OFS_W), .CNT_W(CNT_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .ar_valid (ar_valid),
    .ar_ready (ar_ready),
    .ar_addr  (ar_addr),
    .ar_size  (ar_size),
    .ar_len   (ar_len),
    .ar_burst (ar_burst),
    .r_valid  (r_valid),
    .r_ready  (r_ready),
    .r_last   (r_last),
    .done     (rd_done),
    .bytes    (rd_bytes),
    .err      (rd_err)
  );

  bbm_wr_path #(.STRB_W(STRB_W), .CNT_W(CNT_W)) u_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .aw_valid (aw_valid),
    .aw_ready (aw_ready),
    .aw_size  (aw_size),
    .aw_burst (aw_burst),
    .w_valid  (w_valid),
    .w_ready  (w_ready),
    .w_strb   (w_strb),
    .w_last   (w_last),
    .done     (wr_done),
    .bytes    (wr_bytes),
    .err      (wr_err)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!rd_done && !wr_done && rd_bytes == '0 && wr_bytes == '0)); // R12

endmodule

// File: tb/burst_byte_meter_tb.sv
module burst_byte_meter_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ar_valid = 0, ar_ready = 0;
  logic [1:0] ar_addr = '0;
  logic [2:0] ar_size = '0;
  logic [7:0] ar_len = '0;
  logic [1:0] ar_burst = '0;
  logic r_valid = 0, r_ready = 0, r_last = 0;
  logic aw_valid = 0, aw_ready = 0;
  logic [2:0] aw_size = '0;
  logic [1:0] aw_burst = '0;
  logic w_valid = 0, w_ready = 0, w_last = 0;
  logic [3:0] w_strb = '0;
  logic rd_done, rd_err, wr_done, wr_err;
  logic [10:0] rd_bytes, wr_bytes;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  burst_byte_meter u_dut (
    .clk(clk), .rst_n(rst_n),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_size(ar_size),
    .ar_len(ar_len), .ar_burst(ar_burst),
    .r_valid(r_valid), .r_ready(r_ready), .r_last(r_last),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_size(aw_size), .aw_burst(aw_burst),
    .w_valid(w_valid), .w_ready(w_ready), .w_strb(w_strb), .w_last(w_last),
    .rd_done(rd_done), .rd_bytes(rd_bytes), .rd_err(rd_err),
    .wr_done(wr_done), .wr_bytes(wr_bytes), .wr_err(wr_err)
  );

  typedef struct packed {
    logic [2:0]  sz;
    logic [7:0]  ln;
    logic [15:0] ad;
    logic [1:0]  bt;
    logic [10:0] exp_n;
    logic        exp_e;
  } rvec_t;

  // Expected counts worked out from the requirement formulas.
  localparam rvec_t RTBL [10] = '{
    '{3'd2, 8'd3,   16'h1003, 2'd1, 11'd13,   1'b0}, // R2: 1 + 3*4
    '{3'd1, 8'd2,   16'h1001, 2'd0, 11'd3,    1'b0}, // R3: 3 * 1
    '{3'd2, 8'd0,   16'h1000, 2'd1, 11'd4,    1'b0}, // R2 single beat
    '{3'd0, 8'd4,   16'h0007, 2'd1, 11'd5,    1'b0}, // R2 byte beats
    '{3'd2, 8'd1,   16'h0002, 2'd0, 11'd4,    1'b0}, // R3: 2 * 2
    '{3'd2, 8'd3,   16'h0010, 2'd2, 11'd16,   1'b0}, // R4
    '{3'd2, 8'd1,   16'h0000, 2'd3, 11'd0,    1'b1}, // R5
    '{3'd3, 8'd1,   16'h0000, 2'd1, 11'd0,    1'b1}, // R6
    '{3'd2, 8'd255, 16'h0000, 2'd1, 11'd1024, 1'b0}, // R11
    '{3'd1, 8'd1,   16'h0003, 2'd1, 11'd3,    1'b0}  // R2: 1 + 2
  };

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_read(input rvec_t v);
    @(negedge clk);
    ar_valid = 1; ar_ready = 1;
    ar_size = v.sz; ar_len = v.ln; ar_addr = v.ad[1:0]; ar_burst = v.bt;
    @(negedge clk);
    // R1: pending request with scrambled fields, never accepted
    ar_ready = 0; ar_size = ~v.sz; ar_len = ~v.ln; ar_addr = ~v.ad[1:0]; ar_burst = ~v.bt;
    for (int i = 0; i <= int'(v.ln); i++) begin
      if (i == int'(v.ln)) begin
        r_valid = 1; r_ready = 0; r_last = 1;
        @(negedge clk);
        check("R7 stalled last beat", int'(rd_done), 0);
      end
      r_valid = 1; r_ready = 1; r_last = (i == int'(v.ln));
      @(negedge clk);
    end
    r_valid = 0; r_ready = 0; r_last = 0; ar_valid = 0;
  endtask

  task automatic do_write(input logic [2:0] sz, input logic [1:0] bt, input int nb,
                          input logic [15:0] strbs, input bit stall, input bit pre);
    if (pre) begin
      @(negedge clk);
      w_valid = 1; w_ready = 1; w_strb = 4'hF; w_last = 0;
      @(negedge clk);
      w_valid = 0; w_ready = 0;
    end
    @(negedge clk);
    aw_valid = 1; aw_ready = 1; aw_size = sz; aw_burst = bt;
    @(negedge clk);
    aw_valid = 0; aw_ready = 0; aw_size = ~sz; aw_burst = ~bt;
    for (int i = 0; i < nb; i++) begin
      if (stall && i == 0) begin
        w_valid = 1; w_ready = 0; w_strb = 4'hF; w_last = 0;
        @(negedge clk);
      end
      w_valid = 1; w_ready = 1; w_strb = strbs[i*4 +: 4]; w_last = (i == nb - 1);
      @(negedge clk);
    end
    w_valid = 0; w_ready = 0; w_last = 0; w_strb = '0;
  endtask

  task automatic wr_case(input string req, input logic [2:0] sz, input logic [1:0] bt,
                         input int nb, input logic [15:0] strbs, input bit stall,
                         input bit pre, input int exp_n, input int exp_e);
    do_write(sz, bt, nb, strbs, stall, pre);
    check({req, " wr_done"}, int'(wr_done), 1);
    check({req, " wr_bytes"}, int'(wr_bytes), exp_n);
    check({req, " wr_err"}, int'(wr_err), exp_e);
    @(negedge clk);
    check("R9 wr_done one cycle", int'(wr_done), 0);
    check("R13 wr_bytes held", int'(wr_bytes), exp_n);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 rd_done", int'(rd_done), 0);
    check("R12 rd_bytes", int'(rd_bytes), 0);
    check("R12 wr_done", int'(wr_done), 0);
    check("R12 wr_err", int'(wr_err), 0);
    rst_n = 1;

    foreach (RTBL[k]) begin
      string tag;
      case (RTBL[k].bt)
        2'd0: tag = "R3";
        2'd1: tag = "R2";
        2'd2: tag = "R4";
        default: tag = "R5";
      endcase
      if (RTBL[k].sz > 3'd2) tag = "R6";
      if (RTBL[k].ln == 8'd255) tag = "R11";
      do_read(RTBL[k]);
      check({"R7 rd_done ", tag}, int'(rd_done), 1);
      check({"R1 + ", tag, " rd_bytes"}, int'(rd_bytes), int'(RTBL[k].exp_n));
      check({tag, " rd_err"}, int'(rd_err), int'(RTBL[k].exp_e));
      @(negedge clk);
      check("R7 rd_done one cycle", int'(rd_done), 0);
      check("R13 rd_bytes held", int'(rd_bytes), int'(RTBL[k].exp_n));
    end

    // R8: 1101 twice = 6; stalled beat ignored in the second case = 4+1+2
    wr_case("R8 two beats", 3'd2, 2'd1, 2, 16'h00DD, 1'b0, 1'b0, 6, 0);
    wr_case("R8 stalled beat", 3'd2, 2'd1, 3, 16'h061F, 1'b1, 1'b0, 7, 0);
    // R9: beat before the request is discarded
    wr_case("R9 restart", 3'd2, 2'd1, 1, 16'h0003, 1'b0, 1'b1, 2, 0);
    // R10: reserved burst and oversized size
    wr_case("R10 reserved", 3'd2, 2'd3, 1, 16'h000F, 1'b0, 1'b0, 0, 1);
    wr_case("R10 oversize", 3'd3, 2'd1, 2, 16'h00FF, 1'b0, 1'b0, 0, 1);
    wr_case("R8 wrap strobes", 3'd2, 2'd2, 2, 16'h0048, 1'b0, 1'b0, 2, 0);

    // R12: reset after activity clears results
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    check("R12 rd_bytes after reset", int'(rd_bytes), 0);
    check("R12 wr_bytes after reset", int'(wr_bytes), 0);
    check("R12 rd_err after reset", int'(rd_err), 0);
    rst_n = 1;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule